// File: doc/BRIEF.md
# Serial Converter Digital Port Model

This block is a synthesizable, device-side model of the digital port of a two-channel, 12-bit sampling converter. A host controller drives three lines: a convert strobe, a shift clock and a serial configuration input. The model answers on a serial data output with an output-enable. It replaces the converter in system simulation or emulation, and it can also watch a host and flag timing errors. The analog side is reduced to two parallel test buses, one per input channel. The 12-bit result is computed arithmetically from these buses, according to the channel code latched in the previous transfer.

The convert strobe does two jobs. Its rising edge starts a conversion of fixed length, counted in system clocks. While the strobe stays high the data output is off. When the conversion ends with the strobe still high, the model parks in a low-power rest state. When the strobe falls, the output turns on and the result leaves MSB first, one bit per falling shift-clock edge. Zeros follow once the last bit is out. During the same transfer the first two configuration bits, taken on rising shift-clock edges, choose the input pairing for the next conversion. All line edges are found by sampling on the system clock.

Top module: `adc_port_model`

## Requirements
- R1: After reset the port is idle: `sdo_en_o`, `asleep_o` and `err_o` are 0, and the channel code is 2'b10, so the first conversion returns `ain0_i`.
- R2: A rising `conv_i` starts a conversion. While `conv_i` stays high, `asleep_o` rises on the CONV_CYC-th system clock edge after the edge that detected the rise. `sdo_en_o` stays 0 whenever the detected `conv_i` level is high.
- R3: Two clocks after `conv_i` falls, `sdo_en_o` is 1 and `sdo_o` carries result bit 11.
- R4: Each detected falling `sck_i` edge moves `sdo_o` to the next lower result bit, down to bit 0.
- R5: After the twelfth falling `sck_i` edge of a transfer, `sdo_o` is 0 for every further edge.
- R6: The first two `sdi_i` bits taken on rising `sck_i` edges of a transfer form the channel code, first bit in position 1 (single-ended flag) and second bit in position 0 (odd/sign). Further `sdi_i` bits in the same transfer do not change the code.
- R7: In single-ended mode (code bit 1 = 1) the result is `ain0_i` for code 2'b10 and `ain1_i` for code 2'b11. The buses are sampled at the start of the conversion.
- R8: In differential mode, code 2'b00 gives `ain0_i - ain1_i` and code 2'b01 gives `ain1_i - ain0_i`, as unsigned straight binary. A negative difference gives 0.
- R9: If `conv_i` falls before the conversion count has expired, `err_o` pulses for one clock. The transfer still delivers the result of that conversion.
- R10: If `conv_i` rises during a transfer that has seen fewer than 12 rising `sck_i` edges, `err_o` pulses for one clock. With 12 or more edges no error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_i | input | 1 | Convert strobe: rise starts a conversion, low enables the output |
| sck_i | input | 1 | Shift clock from the host |
| sdi_i | input | 1 | Serial channel-code input |
| ain0_i | input | 12 | Test value for channel 0 |
| ain1_i | input | 12 | Test value for channel 1 |
| sdo_o | output | 1 | Serial result bit (0 when disabled) |
| sdo_en_o | output | 1 | Output enable; 0 models high impedance |
| asleep_o | output | 1 | High in the post-conversion rest state |
| err_o | output | 1 | One-cycle pulse on a host timing violation |

## Verification
A wrong state register shows within two clocks of a strobe edge: the enable comes up while the strobe is high, the rest flag comes early or late, or a spurious error pulse appears. A wrong shift register or fill counter shows as a bit mismatch on the very next falling shift-clock edge, and beyond bit 0 as a non-zero fill bit. A wrong channel latch does not show in its own frame. It shows one frame later, as a result from the wrong bus or with the wrong sign. For that reason the bench chains many frames and compares every bit of every frame.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int CODE_W = 12;
  localparam int CFG_W  = 2;
  localparam logic [CFG_W-1:0] CHAN_RST = 2'b10;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_CONV  = 2'd1,
    PS_SLEEP = 2'd2,
    PS_XFER  = 2'd3
  } port_state_t;

  // Result arithmetic: single-ended pick or clamped difference.
  function automatic logic [CODE_W-1:0] pick_code(
    input logic [CODE_W-1:0] p0,
    input logic [CODE_W-1:0] p1,
    input logic [CFG_W-1:0]  sel
  );
    logic [CODE_W:0] diff;
    diff = '0;
    if (sel[1]) begin
      return sel[0] ? p1 : p0;
    end
    if (sel[0]) diff = {1'b0, p1} - {1'b0, p0};
    else        diff = {1'b0, p0} - {1'b0, p1};
    return diff[CODE_W] ? '0 : diff[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~lvl_q[i];
    assign fall[i] = ~din[i] & lvl_q[i];
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(CONV_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= '0;
    else if (run && !done)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  // R2
  tmr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              active,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  output logic              sdo_bit,
  output logic [CFG_W-1:0]  chan_q,
  output logic              rise_full,
  output logic              drained
);
  localparam int BC_W = $clog2(DATA_W + 1);
  localparam logic [BC_W-1:0] FULL = BC_W'(DATA_W);
  localparam int CC_W = $clog2(CFG_W + 1);

  logic [DATA_W-1:0] sr_q;
  logic [BC_W-1:0]   rise_cnt, fall_cnt;
  logic [CC_W-1:0]   cfg_cnt;
  logic [CFG_W-1:0]  acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q     <= '0;
      rise_cnt <= '0;
      fall_cnt <= '0;
      cfg_cnt  <= '0;
      acc_q    <= '0;
      chan_q   <= CHAN_RST;
    end else if (load) begin
      sr_q     <= load_val;
      rise_cnt <= '0;
      fall_cnt <= '0;
      cfg_cnt  <= '0;
    end else if (active) begin
      if (sck_fall) begin
        sr_q <= {sr_q[DATA_W-2:0], 1'b0};
        if (fall_cnt != FULL) fall_cnt <= fall_cnt + 1'b1;
      end
      if (sck_rise) begin
        if (rise_cnt != FULL) rise_cnt <= rise_cnt + 1'b1;
        if (cfg_cnt != CC_W'(CFG_W)) begin
          acc_q   <= {acc_q[CFG_W-2:0], sdi};
          cfg_cnt <= cfg_cnt + 1'b1;
          if (cfg_cnt == CC_W'(CFG_W - 1)) chan_q <= {acc_q[CFG_W-2:0], sdi};
        end
      end
    end
  end

  assign sdo_bit   = sr_q[DATA_W-1];
  assign rise_full = (rise_cnt == FULL);
  assign drained   = (fall_cnt == FULL);

  // R5
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && drained) |-> !sdo_bit);
  // R6
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && sck_rise) |=> $stable(chan_q));
endmodule

// File: rtl/adc_port_model.sv
module adc_port_model
  import adc_port_pkg::*;
#(
  parameter int DATA_W   = adc_port_pkg::CODE_W,
  parameter int CONV_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] ain0_i,
  input  logic [DATA_W-1:0] ain1_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              asleep_o,
  output logic              err_o
);
  localparam int LINES = 2;

  port_state_t       state_q;
  logic [LINES-1:0]  lvl_q, rise, fall;
  logic              conv_q, conv_rise, conv_fall, sck_rise, sck_fall;
  logic              conv_start, conv_done, load_xfer;
  logic              sdo_bit, rise_full, drained;
  logic [CFG_W-1:0]  chan_q;
  logic [DATA_W-1:0] result_q;

  adc_edge_sync #(.N(LINES)) u_edges (
    .clk(clk), .rst_n(rst_n), .din({sck_i, conv_i}),
    .lvl_q(lvl_q), .rise(rise), .fall(fall)
  );
  assign conv_q    = lvl_q[0];
  assign conv_rise = rise[0];
  assign conv_fall = fall[0];
  assign sck_rise  = rise[1];
  assign sck_fall  = fall[1];

  assign conv_start = conv_rise && (state_q == PS_IDLE || state_q == PS_XFER);
  assign load_xfer  = conv_fall && (state_q == PS_CONV || state_q == PS_SLEEP);

  adc_conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(conv_start),
    .run(state_q == PS_CONV), .done(conv_done)
  );

  adc_shift_out #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_xfer), .load_val(result_q),
    .active(state_q == PS_XFER), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi(sdi_i), .sdo_bit(sdo_bit), .chan_q(chan_q),
    .rise_full(rise_full), .drained(drained)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      result_q <= '0;
      err_o    <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (conv_start) result_q <= pick_code(ain0_i, ain1_i, chan_q);
      unique case (state_q)
        PS_IDLE:  if (conv_rise) state_q <= PS_CONV;
        PS_CONV: begin
          if (conv_fall) begin
            state_q <= PS_XFER;
            err_o   <= 1'b1;
          end else if (conv_done) begin
            state_q <= PS_SLEEP;
          end
        end
        PS_SLEEP: if (conv_fall) state_q <= PS_XFER;
        PS_XFER: begin
          if (conv_rise) begin
            state_q <= PS_CONV;
            err_o   <= !rise_full;
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign sdo_en_o = (state_q == PS_XFER);
  assign sdo_o    = sdo_en_o ? sdo_bit : 1'b0;
  assign asleep_o = (state_q == PS_SLEEP);

  // R2
  sdo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q |-> !sdo_en_o);
  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> ($past(state_q) == PS_CONV && $past(conv_done)));
  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(state_q) == PS_CONV || $past(state_q) == PS_XFER));
  // R3
  xfer_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en_o) |-> !conv_q);
endmodule

// File: tb/adc_port_model_bench.sv
`timescale 1ns/1ps
module adc_port_model_bench;
  localparam int W  = 12;
  localparam int CC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [W-1:0] ain0 = '0, ain1 = '0;
  logic sdo, sdo_en, asleep, err;
  int n_chk = 0, n_bad = 0, err_seen = 0;
  bit done = 1'b0;
  logic [1:0] cur_code = 2'b10;
  bit pend_short = 1'b0;

  always #5 clk = ~clk;

  adc_port_model #(.DATA_W(W), .CONV_CYC(CC)) u_adc_port_model (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sdi_i(sdi),
    .ain0_i(ain0), .ain1_i(ain1), .sdo_o(sdo), .sdo_en_o(sdo_en),
    .asleep_o(asleep), .err_o(err)
  );

  always @(negedge clk) if (rst_n && err) err_seen++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int a0, input int a1, input logic [1:0] c);
    case (c)
      2'b10: return a0;
      2'b11: return a1;
      2'b00: return (a0 > a1) ? a0 - a1 : 0;
      default: return (a1 > a0) ? a1 - a0 : 0;
    endcase
  endfunction

  task automatic frame(input int a0, input int a1, input logic [1:0] nxt,
                       input int nsck, input bit early, input string tag);
    int exp, e0, exp_err;
    ain0 = W'(a0); ain1 = W'(a1);
    exp = model(a0, a1, cur_code);
    e0 = err_seen;
    exp_err = (pend_short ? 1 : 0) + (early ? 1 : 0);
    conv = 1'b1;
    if (early) begin
      repeat (3) @(negedge clk);
      conv = 1'b0;
    end else begin
      repeat (CC) @(negedge clk);
      check(asleep == 1'b0 && sdo_en == 1'b0, "R2 not yet asleep", asleep, 0);
      @(negedge clk);
      check(asleep == 1'b1, "R2 asleep at count", asleep, 1);
      conv = 1'b0;
    end
    repeat (2) @(negedge clk);
    check(err_seen - e0 == exp_err, early ? "R9 early fall flag" : "R10 frame-end flag",
          err_seen - e0, exp_err);
    check(sdo_en == 1'b1, "R3 enable", sdo_en, 1);
    check(sdo == exp[W-1], {tag, " R3 msb"}, sdo, exp[W-1]);
    for (int k = 0; k < nsck; k++) begin
      sdi = (k == 0) ? nxt[1] : (k == 1) ? nxt[0] : ~nxt[k % 2];
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
      repeat (2) @(negedge clk);
      if (k + 1 < W) check(sdo == exp[W-2-k], {tag, " R4 bit"}, sdo, exp[W-2-k]);
      else           check(sdo == 1'b0, "R5 zero fill", sdo, 0);
    end
    if (nsck >= 2) cur_code = nxt;
    pend_short = (nsck < W);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sdo_en == 0 && asleep == 0 && err == 0, "R1 reset outputs", {sdo_en, asleep, err}, 0);
    // R1: first conversion uses default code 10 (channel 0 alone)
    frame(12'hA5C, 12'h3F0, 2'b00, 14, 1'b0, "R1 default");
    // R8 edges: equal inputs, full scale, negative clamp
    frame(12'h7FF, 12'h7FF, 2'b00, 14, 1'b0, "R8 zero");
    frame(12'hFFF, 12'h000, 2'b01, 14, 1'b0, "R8 full");
    frame(12'hFFF, 12'h000, 2'b11, 14, 1'b0, "R8 clamp");
    // R7 sweep over all codes and value pairs
    for (int i = 0; i < 32; i++) begin
      int v;
      v = i % 8;
      frame(v * 12'h249, (v * 1365 + 291) % 4096, 2'(i + 2), 14, 1'b0, "R7 sweep");
    end
    // R10: short transfer with 5 edges, then next frame expects the flag
    frame(12'h123, 12'h456, 2'b11, 5, 1'b0, "R10 short");
    frame(12'h9AB, 12'hCDE, 2'b10, 12, 1'b0, "R6 after short");
    // R9: early fall, data still delivered
    frame(12'h5A5, 12'h0F0, 2'b10, 14, 1'b1, "R9 early");
    frame(12'h321, 12'h000, 2'b10, 14, 1'b0, "R10 clean");
    // R2 final: output off after strobe rises
    conv = 1'b1;
    repeat (2) @(negedge clk);
    check(sdo_en == 1'b0, "R2 off when high", sdo_en, 0);
    check(err_seen == 2, "R10 total flags", err_seen, 2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule